// File: doc/BRIEF.md
# Adder-Subtractor with Comparison Flags

This block is a purely combinational two's-complement adder/subtractor of parameterized width (32 bits by default). A single control input chooses between A plus B and A minus B. Subtraction reuses the same carry chain: B is inverted bit by bit, and the control bit is fed in as the carry-in to supply the +1. Signed and unsigned operands share the same hardware.

Next to the result, the block produces four condition bits: carry out of the top position, signed overflow, all-zero result and result sign. From these four bits it decodes a complete set of relational predicates, signed and unsigned. To compare two values, drive the control input high and read the predicate outputs. During an addition the predicate outputs are still driven, but their values have no meaning.

Top module: `adsub_cmp_unit`

## Requirements
- R1: With sub_i = 0, res_o equals (a_i + b_i) mod 2^WIDTH, and carry_o equals bit WIDTH of the unsigned sum.
- R2: With sub_i = 1, res_o equals (a_i - b_i) mod 2^WIDTH, and carry_o is 1 exactly when a_i >= b_i as unsigned values (no borrow).
- R3: ovf_o is 1 exactly when the mathematically true signed sum or difference lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R4: zero_o is 1 exactly when every bit of res_o is 0.
- R5: neg_o equals bit WIDTH-1 of res_o.
- R6: With sub_i = 1, eq_o is 1 exactly when a_i equals b_i, and ne_o is always the inverse of eq_o.
- R7: With sub_i = 1, lt_o, le_o, gt_o and ge_o give signed a_i < b_i, <=, > and >=.
- R8: With sub_i = 1, ltu_o, leu_o, gtu_o and geu_o give unsigned a_i < b_i, <=, > and >=.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| sub_i | input | 1 | 1 selects a_i - b_i, 0 selects a_i + b_i |
| res_o | output | WIDTH | Sum or difference |
| carry_o | output | 1 | Carry out of the top bit position |
| ovf_o | output | 1 | Signed overflow |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Result sign bit |
| eq_o | output | 1 | Equal |
| ne_o | output | 1 | Not equal |
| lt_o | output | 1 | Signed less than |
| le_o | output | 1 | Signed less or equal |
| gt_o | output | 1 | Signed greater than |
| ge_o | output | 1 | Signed greater or equal |
| ltu_o | output | 1 | Unsigned less than |
| leu_o | output | 1 | Unsigned less or equal |
| gtu_o | output | 1 | Unsigned greater than |
| geu_o | output | 1 | Unsigned greater or equal |

## Verification
The signed predicates are hardest to exercise. A subtraction that overflows makes the sign bit lie, so only the overflow correction gives the right answer, and random operands seldom land in that region. The stimulus therefore pairs extreme values on purpose: the most negative value minus one, the most positive value minus a negative value, and equal operands. It also includes operands that differ only in the sign bit, where the signed and unsigned orderings disagree. Random vectors then fill in around these cases.

// File: rtl/adsub_pkg.sv
package adsub_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef struct packed {
        logic eq;
        logic ne;
        logic lt;
        logic le;
        logic gt;
        logic ge;
        logic ltu;
        logic leu;
        logic gtu;
        logic geu;
    } rel_t;

    function automatic logic signed_below(input nzcv_t f);
        return f.n ^ f.v;
    endfunction

    function automatic logic unsigned_below(input nzcv_t f);
        return ~f.c;
    endfunction

endpackage

// File: rtl/adsub_ripple.sv
module adsub_ripple #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cmsb_o,
    output logic             cout_o
);
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] b_eff;

    assign b_eff    = b_i ^ {WIDTH{sub_i}};
    assign chain[0] = sub_i;

    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        logic hp;
        assign hp         = a_i[k] ^ b_eff[k];
        assign sum_o[k]   = hp ^ chain[k];
        assign chain[k+1] = (hp & chain[k]) | (a_i[k] & b_eff[k]);
    end

    assign cmsb_o = chain[WIDTH-1];
    assign cout_o = chain[WIDTH];

    // R1 and R2: the bit-level chain matches word arithmetic
    always_comb begin
        if (!$isunknown({a_i, b_i, sub_i})) begin
            assert_sum_R1: assert ({cout_o, sum_o} ==
                ({1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i}))
                else $error("ripple chain disagrees with word sum");
        end
    end
endmodule

// File: rtl/adsub_flags.sv
module adsub_flags
    import adsub_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    input  logic [WIDTH-1:0] sum_i,
    input  logic             cmsb_i,
    input  logic             cout_i,
    output nzcv_t            flags_o
);
    localparam int MSB = WIDTH - 1;

    assign flags_o.n = sum_i[MSB];
    assign flags_o.z = ~|sum_i;
    assign flags_o.c = cout_i;
    assign flags_o.v = cmsb_i ^ cout_i;

    // R3: overflow by operand and result signs
    always_comb begin
        if (!$isunknown({a_i, b_i, sub_i})) begin
            assert_no_overflow_R3: assert (flags_o.v ==
                ((a_i[MSB] == (b_i[MSB] ^ sub_i)) && (sum_i[MSB] != a_i[MSB])))
                else $error("overflow flag inconsistent with operand signs");
        end
    end
endmodule

// File: rtl/adsub_decode.sv
module adsub_decode
    import adsub_pkg::*;
(
    input  nzcv_t flags_i,
    output rel_t  rel_o
);
    logic s_lo;
    logic u_lo;

    assign s_lo = signed_below(flags_i);
    assign u_lo = unsigned_below(flags_i);

    assign rel_o.eq  = flags_i.z;
    assign rel_o.ne  = ~flags_i.z;
    assign rel_o.lt  = s_lo;
    assign rel_o.le  = s_lo | flags_i.z;
    assign rel_o.gt  = ~(s_lo | flags_i.z);
    assign rel_o.ge  = ~s_lo;
    assign rel_o.ltu = u_lo;
    assign rel_o.leu = u_lo | flags_i.z;
    assign rel_o.gtu = ~u_lo & ~flags_i.z;
    assign rel_o.geu = ~u_lo;
endmodule

// File: rtl/adsub_cmp_unit.sv
module adsub_cmp_unit
    import adsub_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] res_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             zero_o,
    output logic             neg_o,
    output logic             eq_o,
    output logic             ne_o,
    output logic             lt_o,
    output logic             le_o,
    output logic             gt_o,
    output logic             ge_o,
    output logic             ltu_o,
    output logic             leu_o,
    output logic             gtu_o,
    output logic             geu_o
);
    logic [WIDTH-1:0] sum;
    logic             cmsb;
    logic             cout;
    nzcv_t            flags;
    rel_t             rel;

    adsub_ripple #(.WIDTH(WIDTH)) u_ripple (
        .a_i(a_i), .b_i(b_i), .sub_i(sub_i),
        .sum_o(sum), .cmsb_o(cmsb), .cout_o(cout)
    );

    adsub_flags #(.WIDTH(WIDTH)) u_flags (
        .a_i(a_i), .b_i(b_i), .sub_i(sub_i),
        .sum_i(sum), .cmsb_i(cmsb), .cout_i(cout), .flags_o(flags)
    );

    adsub_decode u_decode (
        .flags_i(flags), .rel_o(rel)
    );

    assign res_o   = sum;
    assign carry_o = flags.c;
    assign ovf_o   = flags.v;
    assign zero_o  = flags.z;
    assign neg_o   = flags.n;
    assign eq_o    = rel.eq;
    assign ne_o    = rel.ne;
    assign lt_o    = rel.lt;
    assign le_o    = rel.le;
    assign gt_o    = rel.gt;
    assign ge_o    = rel.ge;
    assign ltu_o   = rel.ltu;
    assign leu_o   = rel.leu;
    assign gtu_o   = rel.gtu;
    assign geu_o   = rel.geu;

    // Predicates checked against the operands themselves
    always_comb begin
        if (!$isunknown({a_i, b_i, sub_i})) begin
            assert_eq_R6: assert (!sub_i || (eq_o == (a_i == b_i)))
                else $error("equality predicate wrong");
            assert_ne_R6: assert (ne_o != eq_o)
                else $error("eq and ne not complementary");
            assert_signed_R7: assert (!sub_i ||
                (lt_o == ($signed(a_i) < $signed(b_i))))
                else $error("signed less-than wrong");
            assert_unsigned_R8: assert (!sub_i || (ltu_o == (a_i < b_i)))
                else $error("unsigned less-than wrong");
            assert_carry_R2: assert (!sub_i || (carry_o == (a_i >= b_i)))
                else $error("borrow sense wrong");
        end
    end
endmodule

// File: tb/adsub_cmp_unit_bench.sv
module adsub_cmp_unit_bench;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [W-1:0] a, b, res;
    logic sub;
    logic carry, ovf, zero, neg, eq, ne, lt, le, gt, ge, ltu, leu, gtu, geu;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    adsub_cmp_unit #(.WIDTH(W)) u_adsub_cmp_unit (
        .a_i(a), .b_i(b), .sub_i(sub), .res_o(res),
        .carry_o(carry), .ovf_o(ovf), .zero_o(zero), .neg_o(neg),
        .eq_o(eq), .ne_o(ne), .lt_o(lt), .le_o(le), .gt_o(gt), .ge_o(ge),
        .ltu_o(ltu), .leu_o(leu), .gtu_o(gtu), .geu_o(geu)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s a=%h b=%h sub=%0b actual=%h expected=%h", tag, a, b, sub, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic sv);
        logic [W:0] wide;
        longint sa, sb, t;
        bit ev, sl, ul;
        @(posedge clk);
        a = av; b = bv; sub = sv;
        @(negedge clk);
        sa = longint'($signed(av));
        sb = longint'($signed(bv));
        if (sv) begin
            t    = sa - sb;
            wide = {1'b0, av} - {1'b0, bv};
            wide[W] = (av >= bv);
        end else begin
            t    = sa + sb;
            wide = {1'b0, av} + {1'b0, bv};
        end
        ev = (t > 64'sd2147483647) || (t < -64'sd2147483648);
        chk(sv ? "R2 res" : "R1 res", res, wide[W-1:0]);
        chk(sv ? "R2 carry" : "R1 carry", {31'd0, carry}, {31'd0, wide[W]});
        chk("R3 ovf", {31'd0, ovf}, {31'd0, ev});
        chk("R4 zero", {31'd0, zero}, {31'd0, wide[W-1:0] == '0});
        chk("R5 neg", {31'd0, neg}, {31'd0, wide[W-1]});
        chk("R6 ne", {31'd0, ne}, {31'd0, ~eq});
        if (sv) begin
            sl = sa < sb;
            ul = av < bv;
            chk("R6 eq", {31'd0, eq}, {31'd0, av == bv});
            chk("R7 lt", {31'd0, lt}, {31'd0, sl});
            chk("R7 le", {31'd0, le}, {31'd0, sa <= sb});
            chk("R7 gt", {31'd0, gt}, {31'd0, sa > sb});
            chk("R7 ge", {31'd0, ge}, {31'd0, !sl});
            chk("R8 ltu", {31'd0, ltu}, {31'd0, ul});
            chk("R8 leu", {31'd0, leu}, {31'd0, av <= bv});
            chk("R8 gtu", {31'd0, gtu}, {31'd0, av > bv});
            chk("R8 geu", {31'd0, geu}, {31'd0, !ul});
        end
    endtask

    initial begin
        a = '0; b = '0; sub = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R4 reset zero", {31'd0, zero}, 32'd1);
        chk("R1 reset res", res, '0);
        rst = 1'b0;
        apply(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0);
        apply(32'h0000_0001, 32'hFFFF_FFFF, 1'b0);
        apply(32'h8000_0000, 32'h8000_0000, 1'b0);
        apply(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
        apply(32'h8000_0000, 32'h0000_0001, 1'b1);
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        apply(32'h1234_5678, 32'h1234_5678, 1'b1);
        apply(32'h0000_0000, 32'h0000_0001, 1'b1);
        apply(32'h8000_0005, 32'h0000_0005, 1'b1);
        apply(32'h0000_0005, 32'h8000_0005, 1'b1);
        apply(32'h0000_0000, 32'h0000_0000, 1'b1);
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b1);
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] ra, rb;
            ra = $urandom;
            rb = (i % 7 == 0) ? ra : $urandom;
            if (i % 5 == 1) rb = ra ^ 32'h8000_0000;
            apply(ra, rb, i[0]);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule